// File: doc/BRIEF.md
# Power-Managed Clock Source Selector

This block decides which of three oscillators drives the system clock: the primary oscillator, a secondary low-frequency oscillator, or an internal oscillator block. Software writes a 2-bit source request and a 3-bit internal frequency code. The source request is only stored at first. It is applied when a sleep request moves the block into power-managed mode. On wake the block always returns to the primary oscillator.

A write that tries to change the low bit of the source request is dropped while the secondary oscillator enable is low. The frequency code is different: it reaches the frequency-index output on the cycle after it is written, in any mode.

The block drives a one-hot mux select for the clock switch. It also drives three status flags, each showing that one source is actually running. When all three flags are clear, the low-power RC clock is in charge, or the internal block has not yet settled. The oscillators, the start-up timer and the frequency dividers sit outside the block. They appear here only as ready inputs and as the frequency-index output.

Top module: `pm_clock_selector`

## Requirements
- R1: After reset, `src_q` is 00, `freq_idx` is 000, `pm_active` is 0, `clk_mux_sel` is 001 (primary), and `run_sec` and `run_int` are 0.
- R2: Source codes are 00 primary, 01 secondary, 10 and 11 internal. With `src_we` high and `sec_osc_en` high, `cfg_src` is stored in `src_q` at the next edge.
- R3: With `src_we` high and `sec_osc_en` low, `src_q[1]` takes `cfg_src[1]` and `src_q[0]` keeps its old value.
- R4: `clk_mux_sel` changes only when power-managed mode is entered or left. On entry (`sleep_req` while `pm_active` is 0), it takes the source named by the `src_q` value held before that edge.
- R5: `wake_req` while `pm_active` is 1 clears `pm_active` and sets `clk_mux_sel` to primary at the next edge.
- R6: `clk_mux_sel` is always one-hot: bit 0 is primary, bit 1 is secondary, bit 2 is internal.
- R7: `run_pri` is 1 exactly when primary is selected and `ost_done` is 1.
- R8: `run_int` is 1 exactly when internal is selected, `int_stable` is 1 and `freq_idx` is not 000.
- R9: `run_sec` is 1 exactly when secondary is selected. At most one of the three flags is 1 at any time.
- R10: Frequency codes are 000 RC, then 001 to 110 for 125 kHz, 250 kHz, 500 kHz, 1 MHz, 2 MHz and 4 MHz, and 111 for 8 MHz. With `freq_we` high, `freq_idx` shows `cfg_freq` from the next edge, in any mode.
- R11: `sleep_req` while already in power-managed mode, and `wake_req` outside it, change neither `pm_active` nor `clk_mux_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_we | input | 1 | Write strobe for the source request |
| cfg_src | input | 2 | Source request write data |
| freq_we | input | 1 | Write strobe for the frequency code |
| cfg_freq | input | 3 | Frequency code write data |
| sec_osc_en | input | 1 | Secondary oscillator enabled |
| sleep_req | input | 1 | Enter power-managed mode |
| wake_req | input | 1 | Leave power-managed mode |
| ost_done | input | 1 | Primary start-up timer expired |
| int_stable | input | 1 | Internal oscillator block stable |
| src_q | output | 2 | Stored source request |
| freq_idx | output | 3 | Internal frequency code |
| pm_active | output | 1 | Power-managed mode active |
| clk_mux_sel | output | 3 | One-hot clock mux select |
| run_pri | output | 1 | Primary clock running |
| run_sec | output | 1 | Secondary clock running |
| run_int | output | 1 | Internal block stable and running |

## Verification
On every cycle, the assertions check four things:
- the mux select stays one-hot;
- the mux select moves only together with a change of mode;
- a dropped secondary write leaves the low bit alone, and a stray sleep request leaves the mode and select alone;
- wake returns to primary, and no two flags are ever set together.

Some behaviour only the bench's sweeps can show. The mux must land on the exact source stored before the sleep edge, including when a write lands on that same edge. Each flag must follow its ready input and the frequency code over every combination. The frequency code must take effect immediately both inside and outside power-managed mode.

// File: rtl/pm_clock_selector.sv
module pm_clock_selector (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_we,
  input  logic [1:0] cfg_src,
  input  logic       freq_we,
  input  logic [2:0] cfg_freq,
  input  logic       sec_osc_en,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       ost_done,
  input  logic       int_stable,
  output logic [1:0] src_q,
  output logic [2:0] freq_idx,
  output logic       pm_active,
  output logic [2:0] clk_mux_sel,
  output logic       run_pri,
  output logic       run_sec,
  output logic       run_int
);

  localparam logic [2:0] SEL_PRI = 3'b001;
  localparam logic [2:0] SEL_SEC = 3'b010;
  localparam logic [2:0] SEL_INT = 3'b100;

  logic [1:0] src_nxt;
  logic [2:0] req_sel;

  // the low bit only moves while the secondary oscillator is enabled
  assign src_nxt = {cfg_src[1], sec_osc_en ? cfg_src[0] : src_q[0]};
  assign req_sel = src_q[1] ? SEL_INT : (src_q[0] ? SEL_SEC : SEL_PRI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q       <= 2'b00;
      freq_idx    <= 3'b000;
      pm_active   <= 1'b0;
      clk_mux_sel <= SEL_PRI;
    end else begin
      if (src_we)  src_q    <= src_nxt;
      if (freq_we) freq_idx <= cfg_freq;
      if (!pm_active && sleep_req) begin
        pm_active   <= 1'b1;
        clk_mux_sel <= req_sel;
      end else if (pm_active && wake_req) begin
        pm_active   <= 1'b0;
        clk_mux_sel <= SEL_PRI;
      end
    end
  end

  assign run_pri = clk_mux_sel[0] & ost_done;
  assign run_sec = clk_mux_sel[1];
  assign run_int = clk_mux_sel[2] & int_stable & (freq_idx != 3'b000);

  assert_mux_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(clk_mux_sel) == 1);

  assert_mux_moves_with_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_mux_sel) |-> !$stable(pm_active));

  assert_sec_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_we && !sec_osc_en) |=> src_q[0] == $past(src_q[0]));

  assert_wake_to_primary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_active && wake_req) |=> (!pm_active && clk_mux_sel == SEL_PRI));

  assert_sleep_in_pm_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_active && sleep_req && !wake_req) |=> (pm_active && $stable(clk_mux_sel)));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_pri, run_sec, run_int}));

endmodule

// File: tb/pm_clock_selector_tb_top.sv
module pm_clock_selector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_we = 1'b0, freq_we = 1'b0, sec_osc_en = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, ost_done = 1'b0, int_stable = 1'b0;
  logic [1:0] cfg_src = '0;
  logic [2:0] cfg_freq = '0;
  logic [1:0] src_q;
  logic [2:0] freq_idx, clk_mux_sel;
  logic pm_active, run_pri, run_sec, run_int;

  int checks = 0;
  int errors = 0;
  int m_src = 0, m_freq = 0, m_act = 1;
  bit m_pm = 0;

  always #10 clk = ~clk;

  pm_clock_selector dut_i (
    .clk(clk), .rst_n(rst_n), .src_we(src_we), .cfg_src(cfg_src),
    .freq_we(freq_we), .cfg_freq(cfg_freq), .sec_osc_en(sec_osc_en),
    .sleep_req(sleep_req), .wake_req(wake_req), .ost_done(ost_done),
    .int_stable(int_stable), .src_q(src_q), .freq_idx(freq_idx),
    .pm_active(pm_active), .clk_mux_sel(clk_mux_sel), .run_pri(run_pri),
    .run_sec(run_sec), .run_int(run_int));

  function automatic int act_of(input int s);
    return (s >= 2) ? 4 : ((s == 1) ? 2 : 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 R3 src_q", src_q, m_src);
    chk("R4 R6 clk_mux_sel", clk_mux_sel, m_act);
    chk("R5 R11 pm_active", pm_active, m_pm);
    chk("R10 freq_idx", freq_idx, m_freq);
    chk("R7 run_pri", run_pri, (m_act == 1 && ost_done) ? 1 : 0);
    chk("R9 run_sec", run_sec, (m_act == 2) ? 1 : 0);
    chk("R8 run_int", run_int, (m_act == 4 && int_stable && m_freq != 0) ? 1 : 0);
  endtask

  task automatic step(input bit swe, input int s, input bit fwe, input int f,
                      input bit sen, input bit slp, input bit wk,
                      input bit ost, input bit ist);
    @(negedge clk);
    src_we = swe; cfg_src = s[1:0]; freq_we = fwe; cfg_freq = f[2:0];
    sec_osc_en = sen; sleep_req = slp; wake_req = wk;
    ost_done = ost; int_stable = ist;
    if (!m_pm && slp) begin m_pm = 1; m_act = act_of(m_src); end
    else if (m_pm && wk) begin m_pm = 0; m_act = 1; end
    if (swe) m_src = s[1] * 2 + (sen ? s[0] : m_src % 2);
    if (fwe) m_freq = f;
    @(posedge clk);
    #1;
    check_all();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1 src_q", src_q, 0);
    chk("R1 freq_idx", freq_idx, 0);
    chk("R1 pm_active", pm_active, 0);
    chk("R1 clk_mux_sel", clk_mux_sel, 1);
    chk("R1 run_sec", run_sec, 0);
    chk("R1 run_int", run_int, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3: every old value x new value x enable
    for (int sen = 0; sen < 2; sen++)
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 4; n++) begin
          step(1, p, 0, 0, 1, 0, 0, 0, 0);
          step(1, n, 0, 0, sen[0], 0, 0, 0, 0);
        end

    // R4 R5 R7 R8 R9 R10 R11: per source, sleep, flag sweep, stray requests, wake
    for (int s = 0; s < 4; s++) begin
      step(1, s, 0, 0, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0, 1, 1);
      step(0, 0, 0, 0, 1, 0, 1, 1, 1);
      step(0, 0, 0, 0, 1, 1, 0, 0, 0);
      for (int f = 0; f < 8; f++)
        for (int c = 0; c < 4; c++) begin
          step(0, 0, 1, f, 1, 0, 0, c[0], c[1]);
          step(0, 0, 0, 0, 1, 0, 0, c[0], c[1]);
        end
      step(1, 3 - s, 0, 0, 1, 0, 0, 1, 1);
      step(0, 0, 0, 0, 1, 1, 0, 1, 1);
      step(0, 0, 0, 0, 1, 0, 1, 0, 1);
      for (int c = 0; c < 4; c++)
        step(0, 0, 0, 0, 1, 0, 0, c[0], c[1]);
      step(0, 0, 1, 7 - s, 1, 0, 0, 1, 1);
    end

    // R4: a write on the sleep edge does not affect the source applied
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 4; n++) begin
        step(1, p, 0, 0, 1, 0, 0, 1, 1);
        step(1, n, 1, 5, 1, 1, 0, 1, 1);
        step(0, 0, 0, 0, 1, 0, 1, 1, 1);
      end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule